// File: doc/BRIEF.md
# Panel Self-Refresh State Sequencer

This block tracks a display source through the six states of a panel self-refresh session and reports where the session is. Software arms it with an enable bit, a mode field and a keep-transmitter option. It then asks for self-refresh by raising an entry bit and leaves self-refresh by lowering that bit. Software never drives the hardware-owned moves. These are the entry frame settling into self-refresh, a single-frame update going back to plain self-refresh, and the exit returning to the armed idle state. The block makes each of these moves at the next end-of-frame pulse.

Leaving self-refresh needs the panel to be woken. While the sequencer is in its exit state, it raises a request to send a one-byte write: value 01h to the panel power register at address 600h. It holds that request until the link side acknowledges it. The exit can only finish after that acknowledge. A single-frame-update flag can be posted before a flip. The flag makes the sequencer push one refreshed frame, and the flag clears itself when the sequencer lands in an active state.

Top module: `srf_sequencer`

## Requirements
- R1: While reset is asserted and right after it, the state output is 0, and in_trans_o, sr_active_o, wake_req_o and sfu_pend_o are all 0.
- R2: The state output uses this encoding: 0 off, 1 armed idle, 2 entry (static frame sent), 3 self-refresh with no frame update, 4 self-refresh with one frame update, 5 exit. From state 0 the block moves to state 1 one clock later only when ctl_enable=1, ctl_mode equals MODE_SWTIMER (1 by default) and ctl_xmit_keep=1. Any other combination leaves state 0 unchanged.
- R3: In state 1, ctl_entry=1 moves the block to state 2 on the next clock. State 2 moves to state 3 only on a clock where eof_pulse=1, and otherwise stays in state 2.
- R4: In state 3 with ctl_enable=1, ctl_entry=0 moves the block straight to state 5, never through state 4. This takes priority over a pending single-frame update.
- R5: In state 5, wake_req_o is 1 until a clock where wake_ack=1. wake_addr_o is 0x600 and wake_data_o is 0x01. State 5 moves to state 1 only on an eof_pulse clock that comes after the acknowledge clock.
- R6: sfu_set=1 sets sfu_pend_o on the next clock in any state except 0, and state 0 clears the flag. In state 3 with the flag set (and entry and enable high), the block moves to state 4 and the flag clears on the same clock. State 4 returns to state 3 on eof_pulse. The flag also clears when state 2 moves to state 3.
- R7: sr_active_o is 1 exactly when the state is 3 or 4.
- R8: in_trans_o is 1 exactly when the state is 2, 4 or 5, the states that wait for a hardware-driven move.
- R9: ctl_enable=0 in state 1 or 3 returns the block to state 0 on the next clock. In states 2, 4 and 5 the hardware-driven move completes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_enable | input | 1 | Session enable |
| ctl_entry | input | 1 | Request to enter (1) or leave (0) self-refresh |
| ctl_mode | input | MODE_W | Timing mode; only MODE_SWTIMER arms the block |
| ctl_xmit_keep | input | 1 | Keep-transmitter option, needed to arm when REQ_XMIT=1 |
| sfu_set | input | 1 | Pulse that posts a single-frame update |
| eof_pulse | input | 1 | End-of-frame pulse that paces the hardware-driven moves |
| wake_ack | input | 1 | Wake-up write has been sent |
| state_o | output | 3 | Current state code |
| in_trans_o | output | 1 | A hardware-driven move is pending |
| sr_active_o | output | 1 | Self-refresh active |
| sfu_pend_o | output | 1 | Single-frame update flag |
| wake_req_o | output | 1 | Request to send the wake-up write |
| wake_addr_o | output | WAKE_ADDR_W | Register address of the wake-up write |
| wake_data_o | output | 8 | Data byte of the wake-up write |

## Verification
The bench builds the block with its defaults: a two-bit mode field whose code 1 arms the block, the keep-transmitter option required, the single-frame-update logic present, and the wake write at 0x600 with data 0x01. With these values, the random phase can reach every one of the six states. It can reach the non-arming mode codes and a missing keep-transmitter bit in state 0, and it can raise an acknowledge before, on or after an end-of-frame pulse during exit. It can also post a frame update at the moment the state changes. Directed passes cover the ordering corners: an exit request together with a pending frame update, a disable while a hardware move is pending, and an end-of-frame with no acknowledge.

// File: rtl/srf_pkg.sv
package srf_pkg;

   localparam int ST_W = 3;

   typedef enum logic [ST_W-1:0] {
      ST_OFF    = 3'd0,
      ST_IDLE   = 3'd1,
      ST_ENTRY  = 3'd2,
      ST_SELF   = 3'd3,
      ST_SINGLE = 3'd4,
      ST_EXIT   = 3'd5
   } srf_state_e;

   function automatic logic is_active(input srf_state_e s);
      return (s == ST_SELF) || (s == ST_SINGLE);
   endfunction

   function automatic logic is_hw_wait(input srf_state_e s);
      return (s == ST_ENTRY) || (s == ST_SINGLE) || (s == ST_EXIT);
   endfunction

endpackage

// File: rtl/srf_fsm.sv
module srf_fsm
   import srf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       arm_ok,
   input  logic       enable,
   input  logic       entry,
   input  logic       eof,
   input  logic       sfu_flag,
   input  logic       wake_done,
   output srf_state_e state_q,
   output srf_state_e state_d
);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_OFF:    if (arm_ok) state_d = ST_IDLE;
         ST_IDLE: begin
            if (!enable)     state_d = ST_OFF;
            else if (entry)  state_d = ST_ENTRY;
         end
         ST_ENTRY:  if (eof) state_d = ST_SELF;
         ST_SELF: begin
            if (!enable)        state_d = ST_OFF;
            else if (!entry)    state_d = ST_EXIT;
            else if (sfu_flag)  state_d = ST_SINGLE;
         end
         ST_SINGLE: if (eof) state_d = ST_SELF;
         ST_EXIT:   if (eof && wake_done) state_d = ST_IDLE;
         default:   state_d = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_OFF;
      else        state_q <= state_d;
   end

   a_r2_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OFF && !enable) |=> state_q == ST_OFF);
   a_r3_entry_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ENTRY && !eof) |=> state_q == ST_ENTRY);
   a_r4_direct_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SELF && enable && !entry) |=> state_q == ST_EXIT);
   a_r5_no_early_return: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EXIT && !wake_done) |=> state_q == ST_EXIT);
   a_r9_fast_disable: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_IDLE || state_q == ST_SELF) && !enable) |=> state_q == ST_OFF);

endmodule

// File: rtl/srf_sfu_flag.sv
module srf_sfu_flag
   import srf_pkg::*;
#(
   parameter bit SFU_EN = 1'b1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sfu_set,
   input  srf_state_e state_q,
   input  srf_state_e state_d,
   output logic       flag_q
);

   generate
      if (SFU_EN) begin : g_flag
         logic landing;
         assign landing = is_active(state_d) && (state_d != state_q);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  flag_q <= 1'b0;
            else if (state_q == ST_OFF)  flag_q <= 1'b0;
            else if (sfu_set)            flag_q <= 1'b1;
            else if (landing)            flag_q <= 1'b0;
         end

         a_r6_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == ST_SELF && state_d == ST_SINGLE && !sfu_set) |=> !flag_q);
         a_r6_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == ST_OFF) |=> !flag_q);
      end else begin : g_none
         assign flag_q = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/srf_wake.sv
module srf_wake
   import srf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  srf_state_e state_q,
   input  logic       wake_ack,
   output logic       req_o,
   output logic       done_q
);

   assign req_o = (state_q == ST_EXIT) && !done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   done_q <= 1'b0;
      else if (state_q != ST_EXIT)  done_q <= 1'b0;
      else if (req_o && wake_ack)   done_q <= 1'b1;
   end

   a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !wake_ack) |=> req_o);

endmodule

// File: rtl/srf_sequencer.sv
module srf_sequencer
   import srf_pkg::*;
#(
   parameter int          MODE_W       = 2,
   parameter int          MODE_SWTIMER = 1,
   parameter bit          REQ_XMIT     = 1'b1,
   parameter bit          SFU_EN       = 1'b1,
   parameter int          WAKE_ADDR_W  = 20,
   parameter logic [31:0] WAKE_ADDR    = 32'h600,
   parameter logic [7:0]  WAKE_DATA    = 8'h01
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ctl_enable,
   input  logic                   ctl_entry,
   input  logic [MODE_W-1:0]      ctl_mode,
   input  logic                   ctl_xmit_keep,
   input  logic                   sfu_set,
   input  logic                   eof_pulse,
   input  logic                   wake_ack,
   output logic [ST_W-1:0]        state_o,
   output logic                   in_trans_o,
   output logic                   sr_active_o,
   output logic                   sfu_pend_o,
   output logic                   wake_req_o,
   output logic [WAKE_ADDR_W-1:0] wake_addr_o,
   output logic [7:0]             wake_data_o
);

   localparam logic [MODE_W-1:0] ARM_CODE = MODE_W'(MODE_SWTIMER);

   generate
      if (MODE_W < 1 || MODE_SWTIMER < 0 || MODE_SWTIMER >= (1 << MODE_W)) begin : g_bad_mode
         $error("srf_sequencer: MODE_SWTIMER does not fit in MODE_W bits");
      end
      if (WAKE_ADDR_W < 1 || WAKE_ADDR_W > 32 ||
          (WAKE_ADDR_W < 32 && (WAKE_ADDR >> WAKE_ADDR_W) != 0)) begin : g_bad_addr
         $error("srf_sequencer: WAKE_ADDR does not fit in WAKE_ADDR_W bits");
      end
   endgenerate

   srf_state_e state_q, state_d;
   logic       arm_ok, flag_q, done_q;

   generate
      if (REQ_XMIT) begin : g_arm_xmit
         assign arm_ok = ctl_enable && (ctl_mode == ARM_CODE) && ctl_xmit_keep;
      end else begin : g_arm_plain
         logic unused_xmit;
         assign unused_xmit = ctl_xmit_keep;
         assign arm_ok = ctl_enable && (ctl_mode == ARM_CODE);
      end
   endgenerate

   srf_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm_ok    (arm_ok),
      .enable    (ctl_enable),
      .entry     (ctl_entry),
      .eof       (eof_pulse),
      .sfu_flag  (flag_q),
      .wake_done (done_q),
      .state_q   (state_q),
      .state_d   (state_d)
   );

   srf_sfu_flag #(.SFU_EN(SFU_EN)) u_sfu (
      .clk     (clk),
      .rst_n   (rst_n),
      .sfu_set (sfu_set),
      .state_q (state_q),
      .state_d (state_d),
      .flag_q  (flag_q)
   );

   srf_wake u_wake (
      .clk      (clk),
      .rst_n    (rst_n),
      .state_q  (state_q),
      .wake_ack (wake_ack),
      .req_o    (wake_req_o),
      .done_q   (done_q)
   );

   assign state_o     = state_q;
   assign in_trans_o  = is_hw_wait(state_q);
   assign sr_active_o = is_active(state_q);
   assign sfu_pend_o  = flag_q;
   assign wake_addr_o = WAKE_ADDR[WAKE_ADDR_W-1:0];
   assign wake_data_o = WAKE_DATA;

   a_r7_active_entered: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sr_active_o) |-> $past(state_q) == ST_ENTRY);
   a_r8_trans_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_trans_o) |-> ($past(state_q) == ST_IDLE || $past(state_q) == ST_SELF));

endmodule

// File: tb/srf_sequencer_bench.sv
`timescale 1ns/1ps
module srf_sequencer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 0, entry = 0, xk = 0, sfu = 0, eof = 0, ack = 0;
   logic [1:0]  mode = 0;
   logic [2:0]  st;
   logic        itr, act, pend, wreq;
   logic [19:0] waddr;
   logic [7:0]  wdata;

   int n_run = 0;
   int n_fail = 0;
   bit ended = 0;

   // model state
   int  m_s = 0;
   bit  m_f = 0;
   bit  m_wd = 0;

   always #2.5 clk = ~clk;

   srf_sequencer u_srf_sequencer (
      .clk(clk), .rst_n(rst_n), .ctl_enable(en), .ctl_entry(entry),
      .ctl_mode(mode), .ctl_xmit_keep(xk), .sfu_set(sfu), .eof_pulse(eof),
      .wake_ack(ack), .state_o(st), .in_trans_o(itr), .sr_active_o(act),
      .sfu_pend_o(pend), .wake_req_o(wreq), .wake_addr_o(waddr), .wake_data_o(wdata)
   );

   function automatic int next_state(int s, bit f, bit wd);
      case (s)
         0: return (en && mode == 2'd1 && xk) ? 1 : 0;
         1: return !en ? 0 : (entry ? 2 : 1);
         2: return eof ? 3 : 2;
         3: return !en ? 0 : (!entry ? 5 : (f ? 4 : 3));
         4: return eof ? 3 : 4;
         5: return (eof && wd) ? 1 : 5;
         default: return 0;
      endcase
   endfunction

   function automatic bit exp_req(int s, bit wd);
      return (s == 5) && !wd;
   endfunction

   task automatic chk(input string tag, input int act_v, input int exp_v, input string what);
      n_run++;
      if (act_v != exp_v) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act_v, exp_v);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag,  int'(st),   m_s, "state");
      chk("R8", int'(itr),  (m_s == 2 || m_s == 4 || m_s == 5) ? 1 : 0, "in_trans");
      chk("R7", int'(act),  (m_s == 3 || m_s == 4) ? 1 : 0, "sr_active");
      chk("R6", int'(pend), int'(m_f), "sfu_pend");
      chk("R5", int'(wreq), int'(exp_req(m_s, m_wd)), "wake_req");
   endtask

   task automatic step(input string tag);
      int  ns;
      bit  nf, nwd;
      ns  = next_state(m_s, m_f, m_wd);
      if (m_s == 0)                              nf = 0;
      else if (sfu)                              nf = 1;
      else if ((ns == 3 || ns == 4) && ns != m_s) nf = 0;
      else                                       nf = m_f;
      nwd = (m_s == 5) ? (m_wd | (exp_req(m_s, m_wd) & ack)) : 1'b0;
      @(posedge clk); #1;
      m_s = ns; m_f = nf; m_wd = nwd;
      check_all(tag);
   endtask

   task automatic drive(input bit e, input bit n, input logic [1:0] md, input bit x,
                        input bit s, input bit f, input bit a);
      en = e; entry = n; mode = md; xk = x; sfu = s; eof = f; ack = a;
   endtask

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      if (!ended) $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(posedge clk);
      #1;
      check_all("R1");
      chk("R5", int'(waddr), 20'h600, "wake_addr");
      chk("R5", int'(wdata), 8'h01, "wake_data");
      rst_n = 1'b1;
      step("R1");

      // R2: arming only with the exact combination
      drive(1, 0, 2'd2, 1, 0, 0, 0); step("R2");
      drive(1, 0, 2'd1, 0, 0, 0, 0); step("R2");
      drive(0, 0, 2'd1, 1, 1, 0, 0); step("R2");
      drive(1, 0, 2'd1, 1, 0, 0, 0); step("R2");
      // R3: entry then wait for end of frame
      drive(1, 1, 2'd1, 1, 0, 0, 0); step("R3");
      step("R3"); step("R3");
      drive(1, 1, 2'd1, 1, 0, 1, 0); step("R3");
      drive(1, 1, 2'd1, 1, 0, 0, 0); step("R3");
      // R6: single frame update
      drive(1, 1, 2'd1, 1, 1, 0, 0); step("R6");
      drive(1, 1, 2'd1, 1, 0, 0, 0); step("R6");
      step("R6");
      drive(1, 1, 2'd1, 1, 0, 1, 0); step("R6");
      drive(1, 1, 2'd1, 1, 0, 0, 0); step("R6");
      // R4: exit beats a pending frame update
      drive(1, 1, 2'd1, 1, 1, 0, 0); step("R6");
      drive(1, 0, 2'd1, 1, 0, 0, 0); step("R4");
      // R5: no return without acknowledge
      drive(1, 0, 2'd1, 1, 0, 1, 0); step("R5");
      drive(1, 0, 2'd1, 1, 0, 1, 1); step("R5");
      drive(1, 0, 2'd1, 1, 0, 0, 0); step("R5");
      drive(1, 0, 2'd1, 1, 0, 1, 0); step("R5");
      // R9: disable during entry waits for the frame
      drive(1, 1, 2'd1, 1, 0, 0, 0); step("R9");
      drive(0, 1, 2'd0, 0, 0, 0, 0); step("R9");
      drive(0, 1, 2'd0, 0, 0, 1, 0); step("R9");
      drive(0, 0, 2'd0, 0, 0, 0, 0); step("R9");
      step("R9");

      // random phase
      for (int i = 0; i < 6000; i++) begin
         drive(($urandom % 32) != 0, ($urandom % 10) != 0,
               (($urandom % 12) == 0) ? 2'($urandom) : 2'd1,
               ($urandom % 8) != 0, ($urandom % 6) == 0,
               ($urandom % 4) == 0, ($urandom % 3) == 0);
         step("R3");
      end

      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule